// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins sitting behind a plain single-cycle register bus. Every pin owns one control word. That word sets the pin's direction, its output value and its pull resistor. It also selects how the pin raises interrupts and holds that pin's pending event. Pad inputs pass through a synchroniser before the detector, which can trigger on a rising edge, a falling edge or either edge. It can also trigger on a high level or a low level. The mode is picked by three independent trigger bits.

Two bank-wide words sit above the per-pin words. One is a read-only view of all pending bits. The other is a pad-ownership word that hands each pin either to GPIO or to an alternate function. A single interrupt line is high while any pin has a pending event and has its interrupt enabled. Software masks a pin by clearing its enable and its pending bit together. It unmasks a pin by clearing the pending bit while setting the enable.

Top module: `gpio_bank`

## Requirements
- R1: Synchronous active-low reset clears every pin word, every pending bit and the pad-ownership word. After reset all pins are undriven inputs with no pull, and the interrupt output is low.
- R2: The pin word for pin i sits at address i, and reads return it the same cycle. Its bit positions are: 0 output enable, 1 output value, 2 input level (read-only), 3 pull enable, 4 pull-up select, 5 interrupt enable, 6 pending, 7 high trigger, 8 low trigger, 9 edge type. Bit 2 shows the pad level two clocks after the pad changes. Writes to bit 2 have no effect.
- R3: pad_oe[i] is high exactly when output enable is set and the pin is owned by GPIO. pad_out[i] equals the output-value bit.
- R4: pad_pull_en[i] follows pull enable. pad_pull_up[i] follows pull-up select, where 1 means pull-up and 0 means pull-down.
- R5: With edge type set, the detector fires on edges. High alone fires on a rising edge, low alone on a falling edge, and both on either edge. Edges are found by comparing the synchronised sample with the one before it. The pending bit sets three clocks after the pad changes.
- R6: With edge type clear, the detector is level sensitive. Low-only fires while the pad is low, and high-only fires while the pad is high. Both set or both clear never fires. The pending bit is set again on every cycle the level matches.
- R7: Writing a pin word with bit 6 at 1 clears that pin's pending bit, and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set. The detector in that cycle uses the configuration held before the write.
- R8: Address NPINS (32) reads the pending bits, with bit i for pin i. Writes to this address are ignored.
- R9: irq is high exactly when some pin has both its pending bit and its interrupt enable set.
- R10: Address NPINS+1 (33) is the pad-ownership word, readable and writable. A 1 in bit i gives pin i to GPIO, and that value appears on pad_gpio_sel[i].
- R11: Reads of addresses above NPINS+1 return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, same cycle |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output drive enable per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction per pin, 1 = up |
| pad_gpio_sel | output | 32 | 1 = pin owned by GPIO, 0 = alternate function |
| irq | output | 1 | Bank interrupt |

## Verification
A directed rising-edge case checks that a rise is caught and that the following fall is not, which separates the edge selection from the level modes. A held low level with clear writes separates sticky level re-assertion from a lost clear. The same case shows that the write cycle still uses the old trigger mode. Direction, pull and ownership words are toggled so that a gating error on pad_oe cannot hide behind the output value. Random pad activity and random bus traffic then run over all addresses, including the read-only and unmapped ones. This exercises every trigger combination against a cycle-level model, so timing slips in the synchroniser and detector show up as mismatches.

// File: rtl/gpio_bank_pkg.sv
// Package: shared field positions and the per-pin configuration type.
// Assumes a 32-bit register bus; bank size must not exceed the bus width.
package gpio_bank_pkg;

    localparam int unsigned BUS_W = 32;

    // Bit positions inside one pin word.
    localparam int unsigned CW_OE = 0;
    localparam int unsigned CW_DO = 1;
    localparam int unsigned CW_DI = 2;
    localparam int unsigned CW_PE = 3;
    localparam int unsigned CW_PU = 4;
    localparam int unsigned CW_IE = 5;
    localparam int unsigned CW_IS = 6;
    localparam int unsigned CW_TH = 7;
    localparam int unsigned CW_TL = 8;
    localparam int unsigned CW_TT = 9;

    typedef struct packed {
        logic trig_type;
        logic trig_low;
        logic trig_high;
        logic irq_en;
        logic pull_up;
        logic pull_en;
        logic out_data;
        logic out_en;
    } pin_cfg_t;

    // Extract the writable configuration fields from a bus word.
    function automatic pin_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        pin_cfg_t c;
        c.out_en    = w[CW_OE];
        c.out_data  = w[CW_DO];
        c.pull_en   = w[CW_PE];
        c.pull_up   = w[CW_PU];
        c.irq_en    = w[CW_IE];
        c.trig_high = w[CW_TH];
        c.trig_low  = w[CW_TL];
        c.trig_type = w[CW_TT];
        return c;
    endfunction

    // Assemble the readable pin word from configuration and live state.
    function automatic logic [BUS_W-1:0] word_from_cfg(input pin_cfg_t c,
                                                       input logic din,
                                                       input logic pend);
        logic [BUS_W-1:0] w;
        w        = '0;
        w[CW_OE] = c.out_en;
        w[CW_DO] = c.out_data;
        w[CW_DI] = din;
        w[CW_PE] = c.pull_en;
        w[CW_PU] = c.pull_up;
        w[CW_IE] = c.irq_en;
        w[CW_IS] = pend;
        w[CW_TH] = c.trig_high;
        w[CW_TL] = c.trig_low;
        w[CW_TT] = c.trig_type;
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchroniser plus one history stage for edge detection.
// Assumes pad inputs are asynchronous; outputs are the current synchronised
// sample and the sample from the previous cycle.
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [W-1:0] meta_q;

    // Shift pad levels through the metastability stage, sample and history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= d;
            cur    <= meta_q;
            prev   <= cur;
        end
    end

endmodule

// File: rtl/gpio_trig_detect.sv
// Module: combinational trigger detector for one pin.
// Assumes cur/prev are already synchronised; the mode comes from three
// independent bits (high, low, edge type).
module gpio_trig_detect
    import gpio_bank_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     cur,
    input  logic     prev,
    output logic     hit
);

    logic rise;
    logic fall;

    // Decode edges from the two samples and pick edge or level mode.
    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (cfg.trig_type) begin
            hit = (cfg.trig_high & rise) | (cfg.trig_low & fall);
        end else begin
            hit = (cfg.trig_high & ~cfg.trig_low & cur)
                | (cfg.trig_low & ~cfg.trig_high & ~cur);
        end
    end

endmodule

// File: rtl/gpio_pin_reg.sv
// Module: configuration register and pending flag of one pin.
// Assumes wr is a decoded write strobe for this pin's word; pending is
// write-one-to-clear and a same-cycle event wins over the clear.
module gpio_pin_reg
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             hit,
    output pin_cfg_t         cfg,
    output logic             pend
);

    // Hold the writable configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg <= cfg_from_word(wdata);
        end
    end

    // Track the pending event: clear on write-one, set on detector hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= (pend & ~(wr & wdata[CW_IS])) | hit;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// Module: top of one GPIO bank: bus decode, per-pin registers, trigger
// detection, pad ownership, read mux and bank interrupt.
// Assumes a single-cycle bus with combinational read data and NPINS <= 32.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter  int unsigned NPINS = 32,
    localparam int unsigned AW    = $clog2(NPINS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pull_en,
    output logic [NPINS-1:0] pad_pull_up,
    output logic [NPINS-1:0] pad_gpio_sel,
    output logic             irq
);

    localparam logic [AW-1:0] ADDR_STAT  = AW'(NPINS);
    localparam logic [AW-1:0] ADDR_PADEN = AW'(NPINS + 1);

    pin_cfg_t         cfg_q [NPINS];
    logic [NPINS-1:0] cur_v;
    logic [NPINS-1:0] prev_v;
    logic [NPINS-1:0] hit_v;
    logic [NPINS-1:0] pend_v;
    logic [NPINS-1:0] ien_v;
    logic [NPINS-1:0] ttype_v;
    logic [NPINS-1:0] wr_v;
    logic [NPINS-1:0] paden_q;
    logic             bus_wr;

    assign bus_wr = bus_en & bus_we;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .cur  (cur_v),
        .prev (prev_v)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign wr_v[i] = bus_wr & (bus_addr == AW'(i));

        gpio_trig_detect u_det (
            .cfg (cfg_q[i]),
            .cur (cur_v[i]),
            .prev(prev_v[i]),
            .hit (hit_v[i])
        );

        gpio_pin_reg u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (wr_v[i]),
            .wdata(bus_wdata),
            .hit  (hit_v[i]),
            .cfg  (cfg_q[i]),
            .pend (pend_v[i])
        );

        assign ien_v[i]       = cfg_q[i].irq_en;
        assign ttype_v[i]     = cfg_q[i].trig_type;
        assign pad_out[i]     = cfg_q[i].out_data;
        assign pad_oe[i]      = cfg_q[i].out_en & paden_q[i];
        assign pad_pull_en[i] = cfg_q[i].pull_en;
        assign pad_pull_up[i] = cfg_q[i].pull_up;
    end

    // Hold pad ownership: 1 gives the pin to GPIO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paden_q <= '0;
        end else if (bus_wr && bus_addr == ADDR_PADEN) begin
            paden_q <= bus_wdata[NPINS-1:0];
        end
    end

    assign pad_gpio_sel = paden_q;

    // Bank interrupt: any pin with a pending, enabled event.
    assign irq = |(pend_v & ien_v);

    // Select the addressed word for the read path; unmapped reads give 0.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == AW'(i)) begin
                bus_rdata = word_from_cfg(cfg_q[i], cur_v[i], pend_v[i]);
            end
        end
        if (bus_addr == ADDR_STAT) begin
            bus_rdata = BUS_W'(pend_v);
        end
        if (bus_addr == ADDR_PADEN) begin
            bus_rdata = BUS_W'(paden_q);
        end
    end

endmodule

// File: rtl/gpio_bank_chk.sv
// Module: assertion checker for gpio_bank, attached with bind.
// Assumes the bound signals are the synchroniser outputs and pin state.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] cur,
    input logic [NPINS-1:0] prev,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] ttype,
    input logic             irq
);

    logic [1:0] since_rst;

    // Count cycles since reset release, saturating, to guard $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: reset leaves nothing pending and the interrupt low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && !irq));

    // R2: the synchronised sample is the pad level from two edges earlier.
    a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (cur == $past(pad_in, 2)));

    // R9: no enabled pin means no interrupt.
    a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
        // R5: in edge mode a pending bit only rises after a sample change.
        a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pend[i]) && $past(ttype[i])) |-> $past(cur[i] != prev[i]));

        // R7: a pending bit only falls after a clear write to its word.
        a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[i]) |-> $past(bus_en && bus_we
                                     && bus_addr == AW'(i) && bus_wdata[CW_IS]));
    end

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pad_in   (pad_in),
    .cur      (cur_v),
    .prev     (prev_v),
    .pend     (pend_v),
    .ien      (ien_v),
    .ttype    (ttype_v),
    .irq      (irq)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic, all
// compared against a cycle-level model built from the requirements.
module tb_gpio_bank;

    localparam int N  = 32;
    localparam int AW = 6;
    localparam logic [31:0] CFG_MASK = 32'h0000_03BB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pads = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_pull_en, pad_pull_up, pad_gpio_sel;
    logic          irq;

    int vectors = 0;
    int fails = 0;
    bit auto_on = 1'b0;

    // Model state.
    logic [31:0]  m_cfg [N];
    logic [N-1:0] m_st, m_paden, m_s1, m_cur, m_prev;

    gpio_bank #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pads), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .pad_gpio_sel(pad_gpio_sel), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic model_hit(input logic [31:0] c, input logic s, input logic p);
        if (c[9]) return (c[7] & s & ~p) | (c[8] & ~s & p);
        return (c[7] & ~c[8] & s) | (c[8] & ~c[7] & ~s);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
        if (a < AW'(N)) return m_cfg[a] | (32'(m_cur[a]) << 2) | (32'(m_st[a]) << 6);
        if (a == AW'(N)) return m_st;
        if (a == AW'(N + 1)) return m_paden;
        return 32'h0;
    endfunction

    // Model update at each rising edge, from inputs held stable since negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_cfg[i] = '0;
            m_st = '0; m_paden = '0; m_s1 = '0; m_cur = '0; m_prev = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                logic wr_i;
                wr_i = bus_en & bus_we & (bus_addr == AW'(i));
                m_st[i] = (m_st[i] & ~(wr_i & bus_wdata[6]))
                        | model_hit(m_cfg[i], m_cur[i], m_prev[i]);
                if (wr_i) m_cfg[i] = bus_wdata & CFG_MASK;
            end
            if (bus_en && bus_we && bus_addr == AW'(N + 1)) m_paden = bus_wdata;
            m_prev = m_cur; m_cur = m_s1; m_s1 = pads;
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        #1;
        if (auto_on) begin
            chk(pad_oe == (m_paden & oe_vec()), "R3 pad_oe", pad_oe, m_paden & oe_vec());
            chk(pad_out == bitvec(1), "R3 pad_out", pad_out, bitvec(1));
            chk(pad_pull_en == bitvec(3), "R4 pull_en", pad_pull_en, bitvec(3));
            chk(pad_pull_up == bitvec(4), "R4 pull_up", pad_pull_up, bitvec(4));
            chk(pad_gpio_sel == m_paden, "R10 gpio_sel", pad_gpio_sel, m_paden);
            chk(irq == |(m_st & bitvec(5)), "R9 irq", irq, |(m_st & bitvec(5)));
            if (bus_addr > AW'(N + 1))
                chk(bus_rdata == 32'h0, "R11 unmapped read", bus_rdata, 32'h0);
            else if (bus_addr == AW'(N))
                chk(bus_rdata == exp_rd(bus_addr), "R8 status read", bus_rdata, exp_rd(bus_addr));
            else
                chk(bus_rdata == exp_rd(bus_addr), "R2 word read", bus_rdata, exp_rd(bus_addr));
        end
    end

    function automatic logic [N-1:0] bitvec(input int b);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_cfg[i][b];
        return v;
    endfunction

    function automatic logic [N-1:0] oe_vec();
        return bitvec(0);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        auto_on = 1'b1;

        // R1: reset state.
        rd(6'd0, d);  chk(d == 32'h0, "R1 pin word after reset", d, 32'h0);
        rd(6'd33, d); chk(d == 32'h0, "R1 pad ownership after reset", d, 32'h0);
        chk(irq == 1'b0 && pad_oe == '0, "R1 irq/oe after reset", {irq, pad_oe[30:0]}, 32'h0);

        // R5: rising edge mode on pin 3; fall must not trigger.
        wr(6'd3, 32'h2A0); idle(4);
        rd(6'd32, d); chk(d[3] == 1'b0, "R5 no event while steady", d, 32'h0);
        pads[3] = 1'b1; idle(4);
        rd(6'd32, d); chk(d[3] == 1'b1, "R5 rising edge caught", d, 32'h8);
        chk(irq == 1'b1, "R9 irq on enabled pin", irq, 1);
        wr(6'd3, 32'h2E0); idle(1);
        rd(6'd32, d); chk(d[3] == 1'b0, "R7 clear by write one", d, 32'h0);
        pads[3] = 1'b0; idle(4);
        rd(6'd32, d); chk(d[3] == 1'b0, "R5 fall ignored in rising mode", d, 32'h0);
        wr(6'd3, 32'h40);

        // R6/R7: low level on pin 5 re-asserts; clear with level held loses.
        wr(6'd5, 32'h120); idle(4);
        rd(6'd32, d); chk(d[5] == 1'b1, "R6 active-low level", d, 32'h20);
        wr(6'd5, 32'h160); idle(1);
        rd(6'd32, d); chk(d[5] == 1'b1, "R7 event wins over clear", d, 32'h20);
        wr(6'd32, 32'hFFFF_FFFF); idle(1);
        rd(6'd32, d); chk(d[5] == 1'b1, "R8 status write ignored", d, 32'h20);
        wr(6'd5, 32'h0E0); idle(1);
        rd(6'd32, d); chk(d[5] == 1'b1, "R7 write cycle uses old mode", d, 32'h20);
        wr(6'd5, 32'h0E0); idle(1);
        rd(6'd32, d); chk(d[5] == 1'b0, "R6 high mode with pad low", d, 32'h0);
        wr(6'd5, 32'h40);

        // R2: input bit read-only and follows pad after two clocks.
        wr(6'd7, 32'h4); idle(1);
        rd(6'd7, d); chk(d == 32'h0, "R2 input bit not writable", d, 32'h0);
        pads[7] = 1'b1; idle(3);
        rd(6'd7, d); chk(d == 32'h4, "R2 input bit follows pad", d, 32'h4);

        // R3/R10: drive needs GPIO ownership; R4 pulls.
        wr(6'd9, 32'h3); idle(1);
        chk(pad_oe[9] == 1'b0, "R10 not owned so not driven", pad_oe[9], 0);
        wr(6'd33, 32'h200); idle(1);
        chk(pad_oe[9] == 1'b1 && pad_out[9] == 1'b1, "R3 driven when owned",
            {pad_oe[9], pad_out[9]}, 32'h3);
        wr(6'd10, 32'h18); idle(1);
        chk(pad_pull_en[10] && pad_pull_up[10], "R4 pull-up on",
            {pad_pull_en[10], pad_pull_up[10]}, 32'h3);

        // R11: unmapped write has no effect.
        wr(6'd50, 32'hFFFF_FFFF); idle(1);
        rd(6'd50, d); chk(d == 32'h0, "R11 unmapped read zero", d, 32'h0);

        // Random phase.
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if ($urandom_range(3) == 0) pads = $urandom;
            bus_en    = $urandom_range(1);
            bus_we    = $urandom_range(1);
            bus_addr  = AW'($urandom_range(40));
            bus_wdata = $urandom;
        end
        idle(2);
        summary();
        $finish;
    end

endmodule